// File: doc/BRIEF.md
# Flash Buffered Factory-Program Engine

This block is the device-side write state machine of a parallel NOR flash that supports a fast factory-programming mode. A host opens the mode with two bus writes: a setup code followed by a confirm code, both at the start address of the target block. The engine then runs a short setup phase. In that phase it checks whether the block is write-protected, whether the programming supply is good, and whether the start address sits on a buffer boundary. If any check fails, the engine leaves the mode and reports the cause in an 8-bit status register.

When setup succeeds, the engine alternates between two phases. In the first, the host streams exactly 512 words into a write buffer. In the second, the engine copies that buffer into the array, which is a small behavioural RAM inside the block, at consecutive addresses that wrap within the target block. While the mode is active, every read returns status and every write is taken as buffer data, even if it looks like a command. The host leaves the mode by writing to an address in another block while the buffer is empty. The device then goes back to array reads.

Outside the mode, a small command set is decoded: show status, show array, and clear the error bits.

Top module: `fbp_engine`

## Requirements
- R1: After reset the engine is idle and its status is 0x80 (bit 7 ready, all other bits 0). In idle, a read returns the array word at `addr` in `rdata` one cycle after `rd_en`. Writing 0x70 switches reads to status as {8'h00, status}, and writing 0xFF switches them back to the array.
- R2: A write of 0x80 followed by a write of 0xD0 enters the mode. From the next cycle, status bit 7 is 0 and every read returns status. Status bit 0 stays 0 for the whole setup phase.
- R3: If the write after 0x80 is anything other than 0xD0, the engine does not enter the mode. Status bits 5 and 4 are set, bit 7 stays 1, and reads return status.
- R4: At the end of setup, a write-protected target block (`blk_lock` bit for that block) gives status 0x92 (bits 7, 4, 1). A low `vpp_ok` gives 0x98 (bits 7, 4, 3). A start address with bits [8:0] not zero gives 0x90. In every one of these cases the mode ends.
- R5: After a successful setup, status reads 0x01 (bit 7 clear, bit 0 set = buffer can be loaded). Every write in the load phase is stored as buffer data, including the codes 0x70, 0xB0 (suspend) and 0xFF. Suspend therefore has no effect.
- R6: Programming starts only after the 512th word of a load. With 511 words loaded, status stays 0x01. After the 512th word, status is 0x00 for exactly PROG_CYC cycles and then returns to 0x01.
- R7: Each programmed buffer goes to consecutive word offsets. The first buffer starts at the start address, and each later buffer continues from where the previous one ended. When the offset passes the last word of the target block, it wraps to the first word of that block.
- R8: A write whose block index differs from the target block, made while the buffer is empty, ends the mode. Status bit 7 becomes 1 and reads return array words again.
- R9: Writing 0x50 in idle clears status bits 5, 4, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe; `rdata` updates on the next edge |
| addr | input | ADDR_W | Word address: block index in the upper bits, offset within the block in the lower bits |
| wdata | input | 16 | Write data: a command code in bits [7:0], or buffer data |
| blk_lock | input | NUM_BLOCKS | Write-protect flag for each block |
| vpp_ok | input | 1 | Programming supply is within range |
| rdata | output | 16 | Read data: an array word, or {8'h00, status} |

## Verification
A wrong control state shows up at the ports on the very next read. Every read made during the mode returns status, so a phase entered too early or too late changes bits 7 and 0 within one cycle. The bench measures the programming busy window to the exact cycle. A wrong address counter, buffer index or wrap point stays hidden until the host leaves the mode. It then shows as array words that differ from a model of consecutive, block-wrapped placement. The bench reads back every touched word of the block after each session.

// File: rtl/fbp_pkg.sv
// Package: shared state type, command codes and status bit positions for the
// buffered factory-program engine. Assumes a fixed 512-word write buffer.
package fbp_pkg;

    localparam int BUF_WORDS = 512;
    localparam int BUF_AW    = 9;

    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_RDSTAT  = 8'h70;
    localparam logic [7:0] CMD_RDARR   = 8'hFF;
    localparam logic [7:0] CMD_CLRERR  = 8'h50;

    localparam int SR_READY = 7;
    localparam int SR_SEQ   = 5;
    localparam int SR_FAIL  = 4;
    localparam int SR_VPP   = 3;
    localparam int SR_LOCK  = 1;
    localparam int SR_AVAIL = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_SETUP,
        ST_LOAD,
        ST_PROG
    } fbp_state_t;

endpackage

// File: rtl/fbp_wbuf.sv
// Module: write buffer storage for one 512-word load.
// One write port, driven by the load counter. One combinational read port,
// driven by the programming counter. The controller guarantees that a load
// and a program phase never overlap, so no arbitration is needed.
module fbp_wbuf
    import fbp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BUF_AW-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [BUF_WORDS];

    // Store one streamed word at the load position.
    always_ff @(posedge clk) begin
        if (we) begin
            store[widx] <= wdata;
        end
    end

    // Present the word selected by the programming counter.
    always_comb begin
        rdata = store[ridx];
    end

endmodule

// File: rtl/fbp_array.sv
// Module: behavioural flash array, a plain RAM of NUM_BLOCKS blocks.
// Programming overwrites a word; there is no erase. Reads are combinational
// and the top registers them. The array is not cleared on reset.
module fbp_array
    import fbp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_BLOCKS = 2,
    parameter int BLK_BUFS   = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [$clog2(NUM_BLOCKS)+BUF_AW+$clog2(BLK_BUFS)-1:0] waddr,
    input  logic [DATA_W-1:0]                    wdata,
    input  logic [$clog2(NUM_BLOCKS)+BUF_AW+$clog2(BLK_BUFS)-1:0] raddr,
    output logic [DATA_W-1:0]                    rdata
);

    localparam int BLK_AW    = BUF_AW + $clog2(BLK_BUFS);
    localparam int ADDR_W    = $clog2(NUM_BLOCKS) + BLK_AW;
    localparam int ARR_WORDS = NUM_BLOCKS << BLK_AW;

    logic [DATA_W-1:0] cells [ARR_WORDS];

    // Program one word into the array.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Drive the word at the read address.
    always_comb begin
        rdata = cells[raddr];
    end

    // Back-to-back program writes step by one offset inside the same block.
    assert_consecutive_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(we)) |->
            (waddr[BLK_AW-1:0] == BLK_AW'($past(waddr[BLK_AW-1:0]) + 1'b1)) &&
            (waddr[ADDR_W-1:BLK_AW] == $past(waddr[ADDR_W-1:BLK_AW])));

endmodule

// File: rtl/fbp_ctrl.sv
// Module: control state machine of the factory-program engine.
// It decodes the idle commands and the setup/confirm pair, runs the setup
// checks, and counts the buffer loads and program cycles. It also keeps the
// status register and the address counter that wraps inside the block.
// Assumes PROG_CYC >= 512 and NUM_BLOCKS >= 2. Writes that arrive during
// setup or programming are dropped.
module fbp_ctrl
    import fbp_pkg::*;
#(
    parameter int NUM_BLOCKS = 2,
    parameter int BLK_BUFS   = 2,
    parameter int SETUP_CYC  = 6,
    parameter int PROG_CYC   = 520
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NUM_BLOCKS)+BUF_AW+$clog2(BLK_BUFS)-1:0] addr,
    input  logic [7:0]             cmd,
    input  logic [NUM_BLOCKS-1:0]  blk_lock,
    input  logic                   vpp_ok,
    output logic                   buf_we,
    output logic [BUF_AW-1:0]      buf_widx,
    output logic [BUF_AW-1:0]      buf_ridx,
    output logic                   arr_we,
    output logic [$clog2(NUM_BLOCKS)+BUF_AW+$clog2(BLK_BUFS)-1:0] arr_waddr,
    output logic [7:0]             status,
    output logic                   show_status
);

    localparam int BLK_IW  = $clog2(NUM_BLOCKS);
    localparam int BLK_AW  = BUF_AW + $clog2(BLK_BUFS);
    localparam int ADDR_W  = BLK_IW + BLK_AW;
    localparam int CNT_MAX = (PROG_CYC > SETUP_CYC) ? PROG_CYC : SETUP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    fbp_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BUF_AW-1:0] ld_idx;
    logic [BLK_IW-1:0] tgt_blk;
    logic [BLK_AW-1:0] start_off;
    logic [BLK_AW-1:0] off;
    logic              e_seq, e_fail, e_vpp, e_lock;

    logic [BLK_IW-1:0] in_blk;
    logic [BLK_AW-1:0] in_off;
    logic              setup_last;
    logic              fail_lock, fail_vpp, fail_align;
    logic              exit_req;
    logic              prog_last;

    // Split the bus address and work out the phase-end and error conditions.
    always_comb begin
        in_blk     = addr[ADDR_W-1:BLK_AW];
        in_off     = addr[BLK_AW-1:0];
        setup_last = (state == ST_SETUP) && (cnt == CNT_W'(SETUP_CYC - 1));
        fail_lock  = blk_lock[tgt_blk];
        fail_vpp   = !vpp_ok;
        fail_align = (start_off[BUF_AW-1:0] != '0);
        exit_req   = (state == ST_LOAD) && wr_en && (ld_idx == '0) && (in_blk != tgt_blk);
        prog_last  = (state == ST_PROG) && (cnt == CNT_W'(PROG_CYC - 1));
    end

    // Advance the mode state, the counters and the error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            ld_idx      <= '0;
            tgt_blk     <= '0;
            start_off   <= '0;
            off         <= '0;
            e_seq       <= 1'b0;
            e_fail      <= 1'b0;
            e_vpp       <= 1'b0;
            e_lock      <= 1'b0;
            show_status <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_en) begin
                        case (cmd)
                            CMD_SETUP: begin
                                tgt_blk   <= in_blk;
                                start_off <= in_off;
                                state     <= ST_CONFIRM;
                            end
                            CMD_RDSTAT: show_status <= 1'b1;
                            CMD_RDARR:  show_status <= 1'b0;
                            CMD_CLRERR: begin
                                e_seq  <= 1'b0;
                                e_fail <= 1'b0;
                                e_vpp  <= 1'b0;
                                e_lock <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_CONFIRM: begin
                    if (wr_en) begin
                        show_status <= 1'b1;
                        if (cmd == CMD_CONFIRM) begin
                            state  <= ST_SETUP;
                            cnt    <= '0;
                            e_seq  <= 1'b0;
                            e_fail <= 1'b0;
                            e_vpp  <= 1'b0;
                            e_lock <= 1'b0;
                        end else begin
                            state  <= ST_IDLE;
                            e_seq  <= 1'b1;
                            e_fail <= 1'b1;
                        end
                    end
                end
                ST_SETUP: begin
                    if (setup_last) begin
                        if (fail_lock || fail_vpp || fail_align) begin
                            state  <= ST_IDLE;
                            e_fail <= 1'b1;
                            e_lock <= fail_lock;
                            e_vpp  <= fail_vpp;
                        end else begin
                            state  <= ST_LOAD;
                            ld_idx <= '0;
                            off    <= start_off;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (exit_req) begin
                        state       <= ST_IDLE;
                        show_status <= 1'b0;
                    end else if (wr_en) begin
                        ld_idx <= ld_idx + 1'b1;
                        if (ld_idx == BUF_AW'(BUF_WORDS - 1)) begin
                            state <= ST_PROG;
                            cnt   <= '0;
                        end
                    end
                end
                ST_PROG: begin
                    cnt <= cnt + 1'b1;
                    if (cnt < CNT_W'(BUF_WORDS)) begin
                        off <= off + 1'b1;
                    end
                    if (prog_last) begin
                        state  <= ST_LOAD;
                        ld_idx <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the buffer and array strobes and assemble the status byte.
    always_comb begin
        buf_we    = (state == ST_LOAD) && wr_en && !exit_req;
        buf_widx  = ld_idx;
        buf_ridx  = cnt[BUF_AW-1:0];
        arr_we    = (state == ST_PROG) && (cnt < CNT_W'(BUF_WORDS));
        arr_waddr = {tgt_blk, off};
        status    = '0;
        status[SR_READY] = (state == ST_IDLE) || (state == ST_CONFIRM);
        status[SR_SEQ]   = e_seq;
        status[SR_FAIL]  = e_fail;
        status[SR_VPP]   = e_vpp;
        status[SR_LOCK]  = e_lock;
        status[SR_AVAIL] = (state == ST_LOAD);
    end

    // A wrong second cycle reports a sequence error and keeps the engine ready.
    assert_bad_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM && wr_en && cmd != CMD_CONFIRM) |=>
            (status[SR_SEQ] && status[SR_FAIL] && status[SR_READY]));

    // A locked target ends setup with the lock and failure bits.
    assert_lock_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_last && blk_lock[tgt_blk]) |=>
            (status[SR_FAIL] && status[SR_LOCK] && status[SR_READY] && !buf_we));

    // The 512th word closes the buffer and starts a busy window.
    assert_full_starts_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_widx == BUF_AW'(BUF_WORDS - 1)) |=>
            (!status[SR_AVAIL] && !status[SR_READY] && arr_we));

    // The array is written only while the buffer cannot accept data.
    assert_no_prog_while_loading_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (!buf_we && !status[SR_AVAIL]));

    // A write to a foreign block with an empty buffer leaves the mode.
    assert_exit_to_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (!show_status && status[SR_READY] && !status[SR_AVAIL]));

endmodule

// File: rtl/fbp_engine.sv
// Module: top of the buffered factory-program engine.
// It connects the controller, the write buffer and the array, and registers
// the read data. The read data is the status byte while status reads are
// selected, and the array word otherwise.
module fbp_engine
    import fbp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_BLOCKS = 2,
    parameter int BLK_BUFS   = 2,
    parameter int SETUP_CYC  = 6,
    parameter int PROG_CYC   = 520,
    parameter int ADDR_W     = $clog2(NUM_BLOCKS) + BUF_AW + $clog2(BLK_BUFS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    input  logic                  vpp_ok,
    output logic [DATA_W-1:0]     rdata
);

    logic              buf_we;
    logic [BUF_AW-1:0] buf_widx;
    logic [BUF_AW-1:0] buf_ridx;
    logic [DATA_W-1:0] buf_rdata;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [DATA_W-1:0] arr_rdata;
    logic [7:0]        status;
    logic              show_status;

    fbp_ctrl #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_BUFS   (BLK_BUFS),
        .SETUP_CYC  (SETUP_CYC),
        .PROG_CYC   (PROG_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .cmd         (wdata[7:0]),
        .blk_lock    (blk_lock),
        .vpp_ok      (vpp_ok),
        .buf_we      (buf_we),
        .buf_widx    (buf_widx),
        .buf_ridx    (buf_ridx),
        .arr_we      (arr_we),
        .arr_waddr   (arr_waddr),
        .status      (status),
        .show_status (show_status)
    );

    fbp_wbuf #(
        .DATA_W (DATA_W)
    ) u_wbuf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (wdata),
        .ridx  (buf_ridx),
        .rdata (buf_rdata)
    );

    fbp_array #(
        .DATA_W     (DATA_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_BUFS   (BLK_BUFS)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (buf_rdata),
        .raddr (addr),
        .rdata (arr_rdata)
    );

    // Register the read data: status while selected, else the array word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= show_status ? {{(DATA_W-8){1'b0}}, status} : arr_rdata;
        end
    end

    // While the mode is active, a read returns the status byte and never an array word.
    assert_mode_reads_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !status[SR_READY]) |=> (rdata[DATA_W-1:8] == '0 && !rdata[SR_READY]));

endmodule

// File: tb/sim_fbp_engine.sv
`timescale 1ns/1ps
module sim_fbp_engine;

    localparam int NB     = 2;
    localparam int BB     = 2;
    localparam int SETUP  = 6;
    localparam int PCYC   = 520;
    localparam int BLKW   = 512 * BB;
    localparam int AW     = $clog2(NB) + $clog2(BLKW);
    localparam int WORDS  = NB * BLKW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [NB-1:0] blk_lock = '0;
    logic          vpp_ok = 1'b1;
    logic [15:0]   rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model [WORDS];
    bit          known [WORDS];
    logic [15:0] bufdat [512];

    fbp_engine #(
        .NUM_BLOCKS (NB),
        .BLK_BUFS   (BB),
        .SETUP_CYC  (SETUP),
        .PROG_CYC   (PCYC)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .blk_lock (blk_lock),
        .vpp_ok   (vpp_ok),
        .rdata    (rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] setup_status(bit lck, bit vok, bit aligned);
        logic [7:0] s;
        s = 8'h80;
        if (lck || !vok || !aligned) s[4] = 1'b1;
        if (lck)  s[1] = 1'b1;
        if (!vok) s[3] = 1'b1;
        return {8'h00, s};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        check(act === exp, req, {16'h0, act}, {16'h0, exp});
    endtask

    // Callers start at a falling edge; each access uses one rising edge.
    task automatic do_wr(input int a, input logic [15:0] d);
        addr  = AW'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int a, output logic [15:0] d);
        addr  = AW'(a);
        rd_en = 1'b1;
        @(negedge clk);
        d     = rdata;
        rd_en = 1'b0;
    endtask

    task automatic poll(output logic [15:0] st, output int n);
        n = 0;
        do begin
            do_rd(0, st);
            n++;
        end while (!st[0] && !st[7] && n < 3000);
    endtask

    // Load bufdat as one buffer and let it program; update the model.
    task automatic load_prog(input int blk, inout int off, input bit first_word_check);
        logic [15:0] st;
        int n;
        for (int i = 0; i < 512; i++) begin
            do_wr(blk * BLKW + i, bufdat[i]);
            if (first_word_check && i == 0) begin
                do_rd(0, st);
                chk16("R5 command code during load kept as data", st, 16'h0001);
            end
        end
        do_rd(0, st);
        chk16("R6 busy right after 512th word", st, 16'h0000);
        poll(st, n);
        chk16("R6 buffer available after programming", st, 16'h0001);
        check(n == PCYC, "R6 busy window length", n, PCYC);
        for (int i = 0; i < 512; i++) begin
            model[blk * BLKW + off] = bufdat[i];
            known[blk * BLKW + off] = 1'b1;
            off = (off + 1) % BLKW;
        end
    endtask

    task automatic enter_mode(input int a, output logic [15:0] st);
        int n;
        do_wr(a, 16'h0080);
        do_wr(a, 16'h00D0);
        do_rd(0, st);
        chk16("R2 busy with buffer unavailable during setup", st, 16'h0000);
        poll(st, n);
    endtask

    task automatic compare_block(input int blk, input string req);
        logic [15:0] d;
        int bad = 0;
        logic [15:0] fa = '0, fe = '0;
        for (int i = 0; i < BLKW; i++) begin
            if (known[blk * BLKW + i]) begin
                do_rd(blk * BLKW + i, d);
                if (d !== model[blk * BLKW + i]) begin
                    if (bad == 0) begin
                        fa = d;
                        fe = model[blk * BLKW + i];
                    end
                    bad++;
                end
            end
        end
        check(bad == 0, req, {16'h0, fa}, {16'h0, fe});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] st, d;
        int off, blk, nbuf, fill;
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) known[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        do_wr(0, 16'h0070);
        do_rd(0, st);
        chk16("R1 reset status", st, 16'h0080);

        // R3 wrong second cycle, then R9 clear
        do_wr(0, 16'h0080);
        do_wr(0, 16'h0040);
        do_rd(0, st);
        chk16("R3 bad confirm status", st, 16'h00B0);
        do_wr(0, 16'h0050);
        do_rd(0, st);
        chk16("R9 clear errors", st, 16'h0080);

        // R4 setup errors
        blk_lock = 2'b10;
        enter_mode(BLKW, st);
        chk16("R4 locked block", st, setup_status(1, 1, 1));
        do_wr(0, 16'h0050);
        blk_lock = '0;
        vpp_ok = 1'b0;
        enter_mode(0, st);
        chk16("R4 low supply", st, setup_status(0, 0, 1));
        do_wr(0, 16'h0050);
        vpp_ok = 1'b1;
        enter_mode(5, st);
        chk16("R4 misaligned start", st, setup_status(0, 1, 0));
        do_wr(0, 16'h0050);
        do_rd(0, st);
        chk16("R9 clear after setup errors", st, 16'h0080);

        // Directed session: block 0 from offset 512, three buffers, wraps.
        enter_mode(512, st);
        chk16("R5 load phase status", st, 16'h0001);
        off = 512;
        for (int i = 0; i < 512; i++) bufdat[i] = 16'($urandom);
        bufdat[0] = 16'h0070;
        bufdat[1] = 16'h00B0;
        bufdat[2] = 16'h00FF;
        load_prog(0, off, 1'b1);
        for (int b = 1; b < 3; b++) begin
            for (int i = 0; i < 511; i++) bufdat[i] = 16'($urandom);
            bufdat[511] = 16'hFFFF;
            if (b == 2) begin
                for (int i = 0; i < 511; i++) do_wr(i, bufdat[i]);
                repeat (20) @(negedge clk);
                do_rd(0, st);
                chk16("R6 no programming with 511 words", st, 16'h0001);
                addr = '0; wdata = bufdat[511]; wr_en = 1'b1;
                @(negedge clk);
                wr_en = 1'b0;
                do_rd(0, st);
                chk16("R6 busy after final word", st, 16'h0000);
                poll(st, fill);
                check(fill == PCYC, "R6 busy window length", fill, PCYC);
                for (int i = 0; i < 512; i++) begin
                    model[off] = bufdat[i];
                    known[off] = 1'b1;
                    off = (off + 1) % BLKW;
                end
            end else begin
                load_prog(0, off, 1'b0);
            end
        end
        do_wr(BLKW + 3, 16'h1234);
        do_rd(0, d);
        chk16("R8 exit returns array data", d, model[0]);
        compare_block(0, "R7 wrapped placement and R5 codes stored");
        do_wr(0, 16'h0070);
        do_rd(0, st);
        chk16("R8 ready after exit", st, 16'h0080);
        do_wr(0, 16'h00FF);
        do_rd(BLKW - 1, d);
        chk16("R1 array read after 0xFF", d, model[BLKW - 1]);

        // Random sessions
        for (int s = 0; s < 5; s++) begin
            blk  = int'($urandom % NB);
            off  = int'($urandom % BB) * 512;
            nbuf = 1 + int'($urandom % 3);
            enter_mode(blk * BLKW + off, st);
            chk16("R5 random session ready to load", st, 16'h0001);
            for (int b = 0; b < nbuf; b++) begin
                fill = (b == nbuf - 1) ? 1 + int'($urandom % 512) : 512;
                for (int i = 0; i < 512; i++)
                    bufdat[i] = (i < fill) ? 16'($urandom) : 16'hFFFF;
                load_prog(blk, off, 1'b0);
            end
            do_wr(((blk + 1) % NB) * BLKW, 16'h0000);
            compare_block(blk, "R7 random session placement");
            do_wr(0, 16'h0070);
            do_rd(0, st);
            chk16("R8 random session exit status", st, 16'h0080);
            do_wr(0, 16'h00FF);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule